// File: doc/BRIEF.md
# DMA Channel Command and Status Register Block

This block is the register file of one DMA channel. Software reaches it through a word-wide request stream and a registered response stream. The control word does not behave like ordinary storage. A write to it is a set of command strobes: some bits raise a status flag, one bit lowers the completion flag, and one bit drops four flags at once. The flags can be read back, and they also drive plain pins that the channel datapath watches: enable, transfer direction, single-update mode and completion. The datapath pulses a done input to raise the completion flag.

Five more words hold the buffer pointers: current, limit, start, stop and initial-current. They are plain read/write storage. Any access that does not use all four byte lanes is dropped. So is any access to an offset that holds no register. Such a write changes nothing, and such a read returns zero.

Requests use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A write has no response. A taken read produces one response beat on the next cycle. That beat stays valid, with unchanged data, until `rsp_ready` is seen high. While a beat is waiting and `rsp_ready` is low, `req_ready` is low, so no new request is taken.

Top module: `dmach_ctrl_regs`

## Requirements
- R1: After synchronous reset, all four flags, all five pointers and `rsp_valid` are zero.
- R2: Writing the control word (offset 0x0) with bit 16 set raises the enable flag. A control write with bit 16 clear leaves the enable flag as it was.
- R3: Control-word bit 18 raises the device-to-memory direction flag. Only the reset command (R6) clears it.
- R4: Control-word bit 17 raises the single-update flag.
- R5: Control-word bit 19 clears the completion flag. A one-cycle `xfer_done` pulse sets it. When both arrive in the same cycle, the flag ends up clear.
- R6: Control-word bit 20 clears the enable, single-update, completion and direction flags together. It overrides any set bit in the same write and any `xfer_done` pulse in the same cycle.
- R7: A read of offset 0x0 returns the flags in these bit positions: bit 24 enable, bit 25 single-update, bit 26 completion, bit 27 direction. Every other bit reads as zero.
- R8: The pointer words sit at these offsets and return exactly the last value written: 0x4000 current, 0x4004 limit, 0x4008 start, 0x400C stop, 0x4200 initial-current.
- R9: A read of an unmapped or unaligned offset returns zero. A write there changes no flag and no pointer.
- R10: An access whose `req_be` is not 4'hF is ignored. The write has no effect, and the read returns zero.
- R11: A read taken at one edge shows `rsp_valid` high after that edge. While `rsp_ready` is low, the response and its data hold, and no new request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset of the register |
| req_be | input | 4 | Byte lanes; only 4'hF is a legal access |
| req_wdata | input | 32 | Write data or command bits |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read response data |
| xfer_done | input | 1 | One-cycle completion pulse from the datapath |
| ch_enable | output | 1 | Enable flag |
| ch_to_mem | output | 1 | Device-to-memory direction flag |
| ch_single | output | 1 | Single-update flag |
| ch_complete | output | 1 | Completion flag |

## Verification
The embedded assertions check, on every cycle, the flag rules that can be stated locally. These are: direction and enable stay set unless a reset command arrives, the reset command empties every flag, a clear beats a same-cycle done pulse, a done pulse alone sets completion, no pointer moves without a write strobe, and a stalled response holds its data. Other behaviours can only be shown by the bench scenarios. These include the exact bit layout of the status word, the offset map, the zero result of illegal or unmapped reads, and the fact that partial-lane writes leave storage unchanged. The bench's cycle-level model compares all of these against the output pins on every clock.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int NUM_PTR   = 5;
  localparam int CSR_OFF   = 'h0;

  localparam int CMD_SET_EN   = 16;
  localparam int CMD_SET_SUPD = 17;
  localparam int CMD_TO_MEM   = 18;
  localparam int CMD_CLR_DONE = 19;
  localparam int CMD_RESET    = 20;
  localparam int CMD_LO       = CMD_SET_EN;
  localparam int CMD_W        = CMD_RESET - CMD_SET_EN + 1;

  localparam int ST_BASE = 24;

  // packs to status bits 27..24 as {dir, complete, single, enable}
  typedef struct packed {
    logic to_mem;
    logic complete;
    logic single;
    logic enable;
  } chan_flags_t;

  function automatic int ptr_offset(input int idx);
    case (idx)
      0:       return 'h4000;
      1:       return 'h4004;
      2:       return 'h4008;
      3:       return 'h400C;
      default: return 'h4200;
    endcase
  endfunction
endpackage

// File: rtl/dmach_bus_port.sv
module dmach_bus_port
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NSEL   = NUM_PTR + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic [DATA_W-1:0]   rd_word,
  output logic [NSEL-1:0]     wr_sel,
  output logic [NSEL-1:0]     rd_sel
);
  localparam int BE_W = DATA_W / 8;

  logic [NSEL-1:0] hit;
  logic            legal;
  logic            take;

  for (genvar k = 0; k < NSEL; k++) begin : g_dec
    localparam int OFF = (k == 0) ? CSR_OFF : ptr_offset(k - 1);
    assign hit[k] = (req_addr == ADDR_W'(OFF));
  end

  assign legal     = (req_be == {BE_W{1'b1}}) && (req_addr[1:0] == 2'b00);
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign wr_sel    = (take && req_write && legal) ? hit : '0;
  assign rd_sel    = legal ? hit : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_read_resp_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

// File: rtl/dmach_flags.sv
module dmach_flags
  import dmach_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_csr,
  input  logic [CMD_W-1:0] cmd,
  input  logic             xfer_done,
  output chan_flags_t      flags
);
  localparam int I_EN   = CMD_SET_EN   - CMD_LO;
  localparam int I_SUPD = CMD_SET_SUPD - CMD_LO;
  localparam int I_MEM  = CMD_TO_MEM   - CMD_LO;
  localparam int I_CLR  = CMD_CLR_DONE - CMD_LO;
  localparam int I_RST  = CMD_RESET    - CMD_LO;

  chan_flags_t nxt;

  always_comb begin
    nxt = flags;
    if (xfer_done) nxt.complete = 1'b1;
    if (wr_csr) begin
      if (cmd[I_EN])   nxt.enable   = 1'b1;
      if (cmd[I_SUPD]) nxt.single   = 1'b1;
      if (cmd[I_MEM])  nxt.to_mem   = 1'b1;
      if (cmd[I_CLR])  nxt.complete = 1'b0;
      if (cmd[I_RST])  nxt          = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= nxt;
  end

  assert_dir_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (flags.to_mem && !(wr_csr && cmd[I_RST])) |=> flags.to_mem);

  assert_en_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (flags.enable && !(wr_csr && cmd[I_RST])) |=> flags.enable);

  assert_reset_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_csr && cmd[I_RST]) |=> (flags == '0));

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_csr && cmd[I_CLR]) |=> !flags.complete);

  assert_done_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !(wr_csr && (cmd[I_CLR] || cmd[I_RST]))) |=> flags.complete);
endmodule

// File: rtl/dmach_ptr_bank.sv
module dmach_ptr_bank #(
  parameter int DATA_W = 32,
  parameter int NUM    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM-1:0]    wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM-1:0]    rd_sel,
  output logic [DATA_W-1:0] rd_word
);
  logic [NUM-1:0][DATA_W-1:0] ptr_q;

  for (genvar i = 0; i < NUM; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)            ptr_q[i] <= '0;
      else if (wr_sel[i]) ptr_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM; i++) begin
      if (rd_sel[i]) rd_word = rd_word | ptr_q[i];
    end
  end

  assert_ptr_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_sel == '0) |=> $stable(ptr_q));

  assert_one_write_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: rtl/dmach_ctrl_regs.sv
module dmach_ctrl_regs
  import dmach_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic                xfer_done,
  output logic                ch_enable,
  output logic                ch_to_mem,
  output logic                ch_single,
  output logic                ch_complete
);
  localparam int NSEL = NUM_PTR + 1;

  logic [NSEL-1:0]   wr_sel;
  logic [NSEL-1:0]   rd_sel;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] ptr_word;
  logic [DATA_W-1:0] status_word;
  chan_flags_t       flags;

  dmach_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSEL(NSEL)) u_port (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rd_word(rd_word), .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  dmach_flags u_flags (
    .clk(clk), .rst(rst),
    .wr_csr(wr_sel[0]),
    .cmd(req_wdata[CMD_LO +: CMD_W]),
    .xfer_done(xfer_done),
    .flags(flags)
  );

  dmach_ptr_bank #(.DATA_W(DATA_W), .NUM(NUM_PTR)) u_ptrs (
    .clk(clk), .rst(rst),
    .wr_sel(wr_sel[NSEL-1:1]), .wdata(req_wdata),
    .rd_sel(rd_sel[NSEL-1:1]), .rd_word(ptr_word)
  );

  always_comb begin
    status_word = '0;
    status_word[ST_BASE +: 4] = flags;
  end

  assign rd_word     = (rd_sel[0] ? status_word : '0) | ptr_word;
  assign ch_enable   = flags.enable;
  assign ch_to_mem   = flags.to_mem;
  assign ch_single   = flags.single;
  assign ch_complete = flags.complete;
endmodule

// File: tb/sim_dmach_ctrl_regs.sv
`timescale 1ns/1ps
module sim_dmach_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1, xfer_done = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, ch_enable, ch_to_mem, ch_single, ch_complete;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  dmach_ctrl_regs u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .xfer_done(xfer_done), .ch_enable(ch_enable),
    .ch_to_mem(ch_to_mem), .ch_single(ch_single), .ch_complete(ch_complete)
  );

  // behavioural reference model
  bit          m_en, m_sp, m_cp, m_dir, m_rv;
  logic [31:0] m_rd;
  logic [31:0] m_ptr [5];

  function automatic int slot(input logic [15:0] a);
    case (a)
      16'h4000: return 0;
      16'h4004: return 1;
      16'h4008: return 2;
      16'h400C: return 3;
      16'h4200: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [15:0] a);
    if (a == 16'h0) return {4'b0, m_dir, m_cp, m_sp, m_en, 24'b0};
    if (slot(a) >= 0) return m_ptr[slot(a)];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    bit acc, legal, wr;
    if (rst) begin
      m_en = 0; m_sp = 0; m_cp = 0; m_dir = 0; m_rv = 0; m_rd = 0;
      for (int i = 0; i < 5; i++) m_ptr[i] = 0;
    end else begin
      acc   = req_valid && (!m_rv || rsp_ready);
      legal = (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
      wr    = acc && req_write && legal;
      if (acc && !req_write) begin
        m_rv = 1; m_rd = legal ? model_read(req_addr) : 32'h0;
      end else if (m_rv && rsp_ready) m_rv = 0;
      if (xfer_done) m_cp = 1;
      if (wr && req_addr == 16'h0) begin
        if (req_wdata[16]) m_en = 1;
        if (req_wdata[17]) m_sp = 1;
        if (req_wdata[18]) m_dir = 1;
        if (req_wdata[19]) m_cp = 0;
        if (req_wdata[20]) begin m_en = 0; m_sp = 0; m_cp = 0; m_dir = 0; end
      end else if (wr && slot(req_addr) >= 0) m_ptr[slot(req_addr)] = req_wdata;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, {28'b0, ch_to_mem, ch_complete, ch_single, ch_enable},
            {28'b0, m_dir, m_cp, m_sp, m_en});
      check(cur_req, {31'b0, rsp_valid}, {31'b0, m_rv});
      if (m_rv) check(cur_req, rsp_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(input bit w, input logic [15:0] a, input logic [31:0] d,
                       input logic [3:0] be, input bit done);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be; xfer_done = done;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 4'hF; xfer_done = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    issue(1, a, d, 4'hF, 0);
  endtask

  task automatic rd(input logic [15:0] a, input logic [3:0] be,
                    input logic [31:0] exp, input string tag);
    issue(0, a, 32'h0, be, 0);
    check(tag, {31'b0, rsp_valid}, 32'h1);
    check(tag, rsp_data, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    rd(16'h0000, 4'hF, 32'h0, "R1");
    rd(16'h4000, 4'hF, 32'h0, "R1");

    cur_req = "R2";
    wr(16'h0, 32'h0001_0000);
    rd(16'h0000, 4'hF, 32'h0100_0000, "R2");
    wr(16'h0, 32'h0);
    rd(16'h0000, 4'hF, 32'h0100_0000, "R2");

    cur_req = "R4";
    wr(16'h0, 32'h0002_0000);
    rd(16'h0000, 4'hF, 32'h0300_0000, "R4");
    cur_req = "R3";
    wr(16'h0, 32'h0004_0000);
    rd(16'h0000, 4'hF, 32'h0B00_0000, "R3");

    cur_req = "R5";
    pulse_done();
    rd(16'h0000, 4'hF, 32'h0F00_0000, "R5");
    wr(16'h0, 32'h0008_0000);
    rd(16'h0000, 4'hF, 32'h0B00_0000, "R5");
    issue(1, 16'h0, 32'h0008_0000, 4'hF, 1);
    rd(16'h0000, 4'hF, 32'h0B00_0000, "R5");

    cur_req = "R7";
    wr(16'h0, 32'hFFE0_FFFF);
    rd(16'h0000, 4'hF, 32'h0B00_0000, "R7");
    pulse_done();
    rd(16'h0000, 4'hF, 32'h0F00_0000, "R7");

    cur_req = "R6";
    issue(1, 16'h0, 32'h0017_0000, 4'hF, 1);
    rd(16'h0000, 4'hF, 32'h0, "R6");
    check("R6", {28'b0, ch_to_mem, ch_complete, ch_single, ch_enable}, 32'h0);

    cur_req = "R8";
    wr(16'h4000, 32'h1111_0001);
    wr(16'h4004, 32'h2222_0002);
    wr(16'h4008, 32'h3333_0003);
    wr(16'h400C, 32'h4444_0004);
    wr(16'h4200, 32'h5555_0005);
    rd(16'h4000, 4'hF, 32'h1111_0001, "R8");
    rd(16'h4004, 4'hF, 32'h2222_0002, "R8");
    rd(16'h4008, 4'hF, 32'h3333_0003, "R8");
    rd(16'h400C, 4'hF, 32'h4444_0004, "R8");
    rd(16'h4200, 4'hF, 32'h5555_0005, "R8");

    cur_req = "R9";
    wr(16'h4010, 32'hDEAD_BEEF);
    wr(16'h4001, 32'hDEAD_BEEF);
    wr(16'h0002, 32'h001F_0000);
    rd(16'h4010, 4'hF, 32'h0, "R9");
    rd(16'h0004, 4'hF, 32'h0, "R9");
    rd(16'h4001, 4'hF, 32'h0, "R9");
    rd(16'h4000, 4'hF, 32'h1111_0001, "R9");
    rd(16'h0000, 4'hF, 32'h0, "R9");

    cur_req = "R10";
    issue(1, 16'h4000, 32'hCAFE_F00D, 4'h3, 0);
    issue(1, 16'h0000, 32'h0001_0000, 4'h7, 0);
    rd(16'h4000, 4'hF, 32'h1111_0001, "R10");
    rd(16'h0000, 4'hF, 32'h0, "R10");
    rd(16'h4004, 4'h1, 32'h0, "R10");

    cur_req = "R11";
    @(negedge clk); rsp_ready = 0;
    issue(0, 16'h4008, 32'h0, 4'hF, 0);
    repeat (3) @(negedge clk);
    check("R11", {31'b0, rsp_valid}, 32'h1);
    check("R11", rsp_data, 32'h3333_0003);
    req_valid = 1; req_write = 1; req_addr = 16'h4008; req_wdata = 32'h0BAD_0BAD;
    #1;
    check("R11", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rsp_ready = 1;
    @(negedge clk);
    check("R11", {31'b0, rsp_valid}, 32'h0);
    rd(16'h4008, 4'hF, 32'h3333_0003, "R11");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule